// File: doc/BRIEF.md
# Bit-Serial Add/Subtract/Decrement Unit

This unit performs 8-bit arithmetic one bit per clock. Over eight consecutive slots, numbered 0 to 7, a sequencer presents one accumulator bit and one operand bit per clock, least-significant bit first. The unit returns one result bit per slot. A single carry flip-flop links each slot to the next.

Subtraction uses the same adder: it feeds the inverted operand and starts with a carry of one. Decrement forces every operand bit to one, which adds 0xFF. In the last slot of any arithmetic operation, the carry out of the most-significant bit is captured into an overflow flag. That flag is exposed so that a skip condition can test it.

The result bits shift into an internal result register from the top. After slot 7 that register holds the complete 8-bit value. When no arithmetic operation is selected, the operand path and the carry are held at zero, so the accumulator bit passes straight through unchanged.

Top module: `serial_adder_unit`

## Requirements
- R1: With operation code 01 (add) applied over slots 0..7, the value on `res_o` one clock after slot 7 equals (A + M) mod 256.
- R2: During slot s, `sum_bit_o` equals bit s of the result of the selected operation, where slot 0 carries the least-significant bit.
- R3: With operation code 10 (subtract), the result equals (A − M) mod 256, formed as A + ~M + 1.
- R4: With operation code 11 (decrement), the result equals (A − 1) mod 256, whatever is on the operand input.
- R5: With operation code 00 (pass), `sum_bit_o` equals the accumulator bit in every slot, the operand bit is ignored, and `res_o` ends equal to A.
- R6: After slot 7 of an add, `ovf_o` equals the carry out of bit 7.
- R7: After slot 7 of a subtract, `ovf_o` is 1 exactly when A ≥ M, meaning no borrow occurred.
- R8: After slot 7 of a decrement, `ovf_o` is 1 exactly when A was nonzero.
- R9: `ovf_o` changes only at the clock edge that ends slot 7 of an arithmetic operation. It holds in slots 0..6 and through pass operations.
- R10: A synchronous active-high `rst` clears `ovf_o` and `res_o` to zero at the next clock edge, including in the middle of an operation.
- R11: Slot 0 always uses the initial carry of the selected operation. A carry left over from the previous operation has no effect, even when that operation directly precedes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation: 00 pass, 01 add, 10 subtract, 11 decrement |
| slot_i | input | 3 | Current bit slot, 0 = LSB, 7 = MSB |
| acc_bit_i | input | 1 | Accumulator bit for this slot |
| opd_bit_i | input | 1 | Operand bit for this slot |
| sum_bit_o | output | 1 | Result bit for this slot (combinational) |
| ovf_o | output | 1 | Overflow flag: final carry of the last arithmetic operation |
| res_o | output | 8 | Result shift register, complete after slot 7 |

## Verification
The bench runs operations back to back with no idle slot between them. It therefore catches a unit that lets the carry out of bit 7 spill into slot 0 of the next operation: in that case 0x80 + 0x80 would read 0x01 instead of 0x00.

The subtract and decrement boundaries each have their own vectors:
- equal operands and a zero minuend, which catch a missing initial carry or an inverted borrow sense;
- decrement of zero, which catches a decrement that honours the operand input.

The flag is sampled in the middle of an operation and after pass operations. This catches a flag that follows the carry in every slot, or that is cleared by non-arithmetic work. A reset taken in the middle of an operation checks that both the flag and the result register clear.

// File: rtl/sau_pkg.sv
package sau_pkg;

    typedef enum logic [1:0] {
        OP_PASS = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_DEC  = 2'b11
    } sau_op_e;

    // Operand-conditioned inputs of one full-adder step
    typedef struct packed {
        logic a;
        logic b;
        logic cin;
    } fa_in_t;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

    function automatic logic op_is_arith(sau_op_e op);
        return op != OP_PASS;
    endfunction

    function automatic logic op_start_carry(sau_op_e op);
        return op == OP_SUB;
    endfunction

    function automatic fa_out_t full_add(fa_in_t x);
        fa_out_t r;
        r.sum  = x.a ^ x.b ^ x.cin;
        r.cout = (x.a & x.b) | (x.a & x.cin) | (x.b & x.cin);
        return r;
    endfunction

endpackage

// File: rtl/sau_operand_cond.sv
module sau_operand_cond
    import sau_pkg::*;
(
    input  sau_op_e op,
    input  logic    first_slot,
    input  logic    carry_q,
    input  logic    acc_bit,
    input  logic    opd_bit,
    output fa_in_t  fa_in
);

    logic opd_eff;

    always_comb begin
        unique case (op)
            OP_ADD:  opd_eff = opd_bit;
            OP_SUB:  opd_eff = ~opd_bit;
            OP_DEC:  opd_eff = 1'b1;
            default: opd_eff = 1'b0;
        endcase
    end

    always_comb begin
        fa_in.a = acc_bit;
        fa_in.b = opd_eff;
        if (!op_is_arith(op))
            fa_in.cin = 1'b0;
        else if (first_slot)
            fa_in.cin = op_start_carry(op);
        else
            fa_in.cin = carry_q;
    end

endmodule

// File: rtl/sau_carry_stage.sv
module sau_carry_stage
    import sau_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    arith,
    input  fa_in_t  fa_in,
    output fa_out_t fa_out,
    output logic    carry_q
);

    assign fa_out = full_add(fa_in);

    always_ff @(posedge clk) begin
        if (rst)
            carry_q <= 1'b0;
        else if (arith)
            carry_q <= fa_out.cout;
        else
            carry_q <= 1'b0;
    end

endmodule

// File: rtl/sau_ovf_flag.sv
module sau_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic carry_out,
    output logic ovf_q
);

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (capture)
            ovf_q <= carry_out;
    end

    AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(ovf_q)); // R9

    AST_OVF_RESET: assert property (@(posedge clk)
        rst |=> (ovf_q == 1'b0)); // R10

endmodule

// File: rtl/sau_result_shreg.sv
module sau_result_shreg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic [WIDTH-1:0] res_q
);

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else
            res_q <= {bit_in, res_q[WIDTH-1:1]};
    end

    AST_SHIFT_TOP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (res_q[WIDTH-1] == $past(bit_in))); // R1

    AST_RES_RESET: assert property (@(posedge clk)
        rst |=> (res_q == '0)); // R10

endmodule

// File: rtl/serial_adder_unit.sv
module serial_adder_unit
    import sau_pkg::*;
#(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned SLOT_W = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              acc_bit_i,
    input  logic              opd_bit_i,
    output logic              sum_bit_o,
    output logic              ovf_o,
    output logic [WIDTH-1:0]  res_o
);

    localparam logic [SLOT_W-1:0] FIRST_SLOT = '0;
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(WIDTH - 1);

    sau_op_e op;
    logic    arith;
    logic    first_slot;
    logic    last_slot;
    logic    carry_q;
    fa_in_t  fa_in;
    fa_out_t fa_out;

    assign op         = sau_op_e'(op_i);
    assign arith      = op_is_arith(op);
    assign first_slot = (slot_i == FIRST_SLOT);
    assign last_slot  = (slot_i == LAST_SLOT);

    sau_operand_cond u_cond (
        .op         (op),
        .first_slot (first_slot),
        .carry_q    (carry_q),
        .acc_bit    (acc_bit_i),
        .opd_bit    (opd_bit_i),
        .fa_in      (fa_in)
    );

    sau_carry_stage u_carry (
        .clk     (clk),
        .rst     (rst),
        .arith   (arith),
        .fa_in   (fa_in),
        .fa_out  (fa_out),
        .carry_q (carry_q)
    );

    sau_ovf_flag u_ovf (
        .clk       (clk),
        .rst       (rst),
        .capture   (arith && last_slot),
        .carry_out (fa_out.cout),
        .ovf_q     (ovf_o)
    );

    sau_result_shreg #(.WIDTH(WIDTH)) u_res (
        .clk    (clk),
        .rst    (rst),
        .bit_in (fa_out.sum),
        .res_q  (res_o)
    );

    assign sum_bit_o = fa_out.sum;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PASS) |-> (sum_bit_o == acc_bit_i)); // R5

    AST_ADD_FRESH_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD && first_slot) |-> (sum_bit_o == (acc_bit_i ^ opd_bit_i))); // R11

    AST_DEC_LSB: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DEC && first_slot) |-> (sum_bit_o == ~acc_bit_i)); // R4

    AST_SUB_LSB: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUB && first_slot) |-> (sum_bit_o == (acc_bit_i ^ opd_bit_i))); // R3

endmodule

// File: tb/serial_adder_unit_test.sv
`timescale 1ns/1ps
module serial_adder_unit_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] op_i;
    logic [2:0] slot_i;
    logic       acc_bit_i;
    logic       opd_bit_i;
    logic       sum_bit_o;
    logic       ovf_o;
    logic [7:0] res_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    serial_adder_unit uut (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .slot_i    (slot_i),
        .acc_bit_i (acc_bit_i),
        .opd_bit_i (opd_bit_i),
        .sum_bit_o (sum_bit_o),
        .ovf_o     (ovf_o),
        .res_o     (res_o)
    );

    // Fields: op[26:25] A[24:17] M[16:9] result[8:1] flag[0]
    localparam int NV = 16;
    localparam logic [26:0] VECS [NV] = '{
        {2'b01, 8'h03, 8'h04, 8'h07, 1'b0},
        {2'b01, 8'hFF, 8'h01, 8'h00, 1'b1},
        {2'b01, 8'h80, 8'h80, 8'h00, 1'b1}, // R11: carry from previous must not leak
        {2'b01, 8'h55, 8'hAA, 8'hFF, 1'b0},
        {2'b10, 8'h86, 8'h0C, 8'h7A, 1'b1},
        {2'b10, 8'h0C, 8'h86, 8'h86, 1'b0},
        {2'b10, 8'h42, 8'h42, 8'h00, 1'b1},
        {2'b10, 8'h00, 8'h01, 8'hFF, 1'b0},
        {2'b11, 8'h00, 8'hA5, 8'hFF, 1'b0},
        {2'b11, 8'h01, 8'h00, 8'h00, 1'b1},
        {2'b11, 8'h80, 8'hFF, 8'h7F, 1'b1},
        {2'b00, 8'h3C, 8'hFF, 8'h3C, 1'b1}, // flag held from previous
        {2'b01, 8'h7F, 8'h01, 8'h80, 1'b0},
        {2'b00, 8'hC3, 8'h5A, 8'hC3, 1'b0}, // flag held from previous
        {2'b10, 8'h10, 8'h20, 8'hF0, 1'b0},
        {2'b01, 8'hFF, 8'hFF, 8'hFE, 1'b1}
    };

    function automatic string res_tag(logic [1:0] op);
        case (op)
            2'b01:   return "R1";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic string ovf_tag(logic [1:0] op);
        case (op)
            2'b01:   return "R6";
            2'b10:   return "R7";
            2'b11:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] stream;
        logic [7:0] exp_res;
        logic       exp_ovf;
        logic       prev_ovf;
        string      rtag;
        string      otag;

        rst = 1'b1; op_i = 2'b00; slot_i = 3'd0; acc_bit_i = 1'b0; opd_bit_i = 1'b0;
        stream = '0; exp_res = '0; exp_ovf = 1'b0; prev_ovf = 1'b0;
        rtag = "R1"; otag = "R6";
        repeat (3) @(negedge clk);
        check("R10 reset result", res_o, 8'h00);
        check("R10 reset flag", {7'b0, ovf_o}, 8'h00);
        rst = 1'b0;

        // Back-to-back operations: outputs of vector v are sampled at the
        // negedge where slot 0 of vector v+1 is driven (before any edge).
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                if (s == 0 && v > 0) begin
                    check({"R2 stream ", rtag}, stream, exp_res);
                    check(rtag, res_o, exp_res);
                    check(otag, {7'b0, ovf_o}, {7'b0, exp_ovf});
                end
                if (s == 0) begin
                    prev_ovf = (v > 0) ? exp_ovf : 1'b0;
                    exp_res  = VECS[v][8:1];
                    exp_ovf  = VECS[v][0];
                    rtag     = res_tag(VECS[v][26:25]);
                    otag     = ovf_tag(VECS[v][26:25]);
                end
                if (s == 4)
                    check("R9 flag mid-operation", {7'b0, ovf_o}, {7'b0, prev_ovf});
                op_i      = VECS[v][26:25];
                slot_i    = 3'(s);
                acc_bit_i = VECS[v][17 + s];
                opd_bit_i = VECS[v][9 + s];
                #1;
                stream[s] = sum_bit_o;
            end
        end
        @(negedge clk);
        op_i = 2'b00; slot_i = 3'd0; acc_bit_i = 1'b0; opd_bit_i = 1'b0;
        check({"R2 stream ", rtag}, stream, exp_res);
        check(rtag, res_o, exp_res);
        check(otag, {7'b0, ovf_o}, {7'b0, exp_ovf});

        // Reset taken in the middle of an add, with flag set and result nonzero
        op_i = 2'b01;
        for (int s = 0; s < 3; s++) begin
            slot_i = 3'(s); acc_bit_i = 1'b1; opd_bit_i = 1'b1;
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; op_i = 2'b00;
        check("R10 mid-op reset result", res_o, 8'h00);
        check("R10 mid-op reset flag", {7'b0, ovf_o}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule